// File: doc/BRIEF.md
# Dual-Mode Frequency and Duty Meter

This block measures the frequency of a single digital input and reports it in hertz. It also reports the duty cycle in percent when that is available. All of its logic runs on one system clock. The input first passes through a synchronizer, and the block then uses the input's edges as enables.

Two methods are available, and a one-cycle button pulse switches between them:

- **Period method.** Suited to slow inputs. It times the high and low phases of one full input cycle in system-clock ticks. It derives the frequency from their sum and the duty cycle from their ratio.
- **Reciprocal method.** Suited to fast inputs. It opens a measurement window whose edges are aligned to rising edges of the input. Over that window it counts input cycles (Nx) and system-clock cycles (Ns), and it reports CLK_HZ·Nx/Ns.

One shift-subtract divider does every conversion to hertz and percent. Each result arrives with a one-cycle valid strobe. If the input stops toggling, the block reports zero hertz. A mode change discards any measurement that is in progress.

Top module: `freq_duty_meter`

## Requirements
- R1: After reset, `freq_hz` and `duty_pct` are 0, `result_valid` is low and `mode_recip` is 0 (period method).
- R2: A one-cycle high on `btn_toggle` inverts `mode_recip` at the next clock edge. The value 0 selects the period method and 1 selects the reciprocal method.
- R3: In period mode, let H and L be the exact numbers of system-clock cycles for which the synchronized input stayed high and then low. The reported frequency is floor(CLK_HZ/(H+L)). Only complete high-then-low pairs that start at a rising edge seen after reset or abort are used.
- R4: In period mode, `duty_pct` is floor(100·H/(H+L)) and never exceeds 100.
- R5: In reciprocal mode, the reported frequency is floor(CLK_HZ·Nx/Ns). For an input with a constant period of P system cycles, this equals floor(CLK_HZ/P). `duty_pct` is reported as 0 in this mode.
- R6: In reciprocal mode, a nominal window stays open for GATE_TICKS cycles. The effective window opens and closes only on rising edges of the synchronized input, and Nx never exceeds Ns. For this reason, a result cannot appear sooner than GATE_TICKS cycles after an abort.
- R7: `result_valid` is high for exactly one cycle per result.
- R8: If the input has no edge for TIMEOUT_TICKS consecutive cycles, the block reports frequency 0 and duty 0 with `result_valid`. While the input stays silent, this repeats every TIMEOUT_TICKS cycles.
- R9: A mode toggle aborts the running measurement and conversion. `result_valid` is low in the cycle after the toggle, and the next result comes from the newly selected method.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, whose frequency is CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| sig_in | input | 1 | Input to be measured (asynchronous) |
| btn_toggle | input | 1 | Debounced one-cycle pulse that switches the method |
| mode_recip | output | 1 | 0 = period method, 1 = reciprocal method |
| freq_hz | output | FREQ_W | Measured frequency in hertz, saturating |
| duty_pct | output | 7 | Duty cycle in percent (period method only) |
| result_valid | output | 1 | One-cycle strobe when a new result is presented |

## Verification
Two situations are the hardest to reach from the ports.

- **Abort during a conversion.** The stimulus keeps a slow period-mode waveform running and waits for a first result. It then toggles the mode partway into the next measurement. The first result after the toggle must then carry a zero duty cycle and must arrive no sooner than one gate window later.
- **Timeout repetition.** The stimulus silences the input and measures the exact cycle distance between two consecutive zero results.

Frequency correctness is swept over many high/low phase lengths down to one cycle each, and over reciprocal periods from 2 to 25 cycles.

// File: rtl/freqm_pkg.sv
package freqm_pkg;

    // period-method phase tracker
    typedef enum logic [1:0] {
        PH_ARM  = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } phase_e;

    // reciprocal-method nominal gate
    typedef enum logic {
        GT_OPEN  = 1'b0,
        GT_CLOSE = 1'b1
    } gate_e;

    // conversion sequencer
    typedef enum logic [1:0] {
        CV_IDLE = 2'd0,
        CV_FREQ = 2'd1,
        CV_DUTY = 2'd2
    } conv_e;

    localparam int unsigned DUTY_W    = 7;
    localparam int unsigned DUTY_FULL = 100;

endpackage

// File: rtl/freqm_edge_sync.sv
module freqm_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    localparam int unsigned SH_W = STAGES + 1;

    typedef struct packed {
        logic [SH_W-1:0] sh;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.sh = {sync_q.sh[SH_W-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    // bit SH_W-2 is the synchronized level, bit SH_W-1 its previous value
    assign rise =  sync_q.sh[SH_W-2] & ~sync_q.sh[SH_W-1];
    assign fall = ~sync_q.sh[SH_W-2] &  sync_q.sh[SH_W-1];

endmodule

// File: rtl/freqm_period.sv
module freqm_period
    import freqm_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             rise,
    input  logic             fall,
    output logic             done,
    output logic [CNT_W-1:0] hi_cnt,
    output logic [CNT_W-1:0] lo_cnt
);
    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] hi;
        logic [CNT_W-1:0] lo;
        logic             done;
    } per_t;

    per_t per_d, per_q;

    always_comb begin
        per_d      = per_q;
        per_d.done = 1'b0;
        if (clr) begin
            per_d.ph  = PH_ARM;
            per_d.cnt = '0;
        end else begin
            unique case (per_q.ph)
                PH_ARM: begin
                    // a partial first phase is never used
                    if (rise) begin
                        per_d.ph  = PH_HIGH;
                        per_d.cnt = CNT_W'(1);
                    end
                end
                PH_HIGH: begin
                    if (fall) begin
                        per_d.hi  = per_q.cnt;
                        per_d.cnt = CNT_W'(1);
                        per_d.ph  = PH_LOW;
                    end else begin
                        per_d.cnt = per_q.cnt + 1'b1;
                    end
                end
                PH_LOW: begin
                    if (rise) begin
                        per_d.lo   = per_q.cnt;
                        per_d.cnt  = CNT_W'(1);
                        per_d.ph   = PH_HIGH;
                        per_d.done = 1'b1;
                    end else begin
                        per_d.cnt = per_q.cnt + 1'b1;
                    end
                end
                default: per_d.ph = PH_ARM;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) per_q <= '0;
        else        per_q <= per_d;
    end

    assign done   = per_q.done;
    assign hi_cnt = per_q.hi;
    assign lo_cnt = per_q.lo;

    // a finished period always holds two non-empty phases
    p_phases_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        per_q.done |-> (per_q.hi != '0 && per_q.lo != '0));

endmodule

// File: rtl/freqm_recip.sv
module freqm_recip
    import freqm_pkg::*;
#(
    parameter int unsigned CNT_W      = 32,
    parameter int unsigned GATE_TICKS = 5_000_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             rise,
    output logic             done,
    output logic [CNT_W-1:0] nx,
    output logic [CNT_W-1:0] ns
);
    localparam int unsigned TMR_W = $clog2(GATE_TICKS + 1);

    typedef struct packed {
        gate_e            st;
        logic [TMR_W-1:0] tmr;
        logic             eff;
        logic [CNT_W-1:0] nx_run;
        logic [CNT_W-1:0] ns_run;
        logic [CNT_W-1:0] nx;
        logic [CNT_W-1:0] ns;
        logic             done;
    } rec_t;

    rec_t rec_d, rec_q;

    always_comb begin
        rec_d      = rec_q;
        rec_d.done = 1'b0;
        if (clr) begin
            rec_d.st     = GT_OPEN;
            rec_d.tmr    = '0;
            rec_d.eff    = 1'b0;
            rec_d.nx_run = '0;
            rec_d.ns_run = '0;
        end else begin
            // effective gate follows the nominal one only at input rising edges
            if (rise) rec_d.eff = (rec_q.st == GT_OPEN);
            if (rec_q.eff) begin
                rec_d.ns_run = rec_q.ns_run + 1'b1;
                if (rise) rec_d.nx_run = rec_q.nx_run + 1'b1;
            end
            unique case (rec_q.st)
                GT_OPEN: begin
                    if (rec_q.tmr == TMR_W'(GATE_TICKS - 1)) begin
                        rec_d.st  = GT_CLOSE;
                        rec_d.tmr = '0;
                    end else begin
                        rec_d.tmr = rec_q.tmr + 1'b1;
                    end
                end
                GT_CLOSE: begin
                    if (!rec_q.eff) begin
                        if (rec_q.nx_run != '0) begin
                            rec_d.nx   = rec_q.nx_run;
                            rec_d.ns   = rec_q.ns_run;
                            rec_d.done = 1'b1;
                        end
                        rec_d.nx_run = '0;
                        rec_d.ns_run = '0;
                        rec_d.st     = GT_OPEN;
                        rec_d.tmr    = '0;
                    end
                end
                default: rec_d.st = GT_OPEN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rec_q <= '0;
        else        rec_q <= rec_d;
    end

    assign done = rec_q.done;
    assign nx   = rec_q.nx;
    assign ns   = rec_q.ns;

    p_nx_within_ns_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rec_q.nx_run <= rec_q.ns_run);

    p_gate_on_edges_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rise && !clr) |=> $stable(rec_q.eff));

endmodule

// File: rtl/freqm_divider.sv
module freqm_divider #(
    parameter int unsigned W = 48
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         done,
    output logic [W-1:0] quotient
);
    localparam int unsigned CNT_BITS = $clog2(W + 1);

    typedef struct packed {
        logic                busy;
        logic                done;
        logic [CNT_BITS-1:0] cnt;
        logic [W:0]          rem;
        logic [W-1:0]        quo;
        logic [W-1:0]        dsr;
    } div_t;

    div_t       div_d, div_q;
    logic [W:0] shifted;

    always_comb begin
        div_d      = div_q;
        div_d.done = 1'b0;
        shifted    = '0;
        if (clr) begin
            div_d.busy = 1'b0;
        end else if (start && !div_q.busy) begin
            div_d.busy = 1'b1;
            div_d.cnt  = CNT_BITS'(W);
            div_d.rem  = '0;
            div_d.quo  = dividend;
            div_d.dsr  = divisor;
        end else if (div_q.busy) begin
            // one quotient bit per cycle, dividend shifted out of quo
            shifted   = {div_q.rem[W-1:0], div_q.quo[W-1]};
            div_d.quo = {div_q.quo[W-2:0], 1'b0};
            if (shifted >= {1'b0, div_q.dsr}) begin
                div_d.rem    = shifted - {1'b0, div_q.dsr};
                div_d.quo[0] = 1'b1;
            end else begin
                div_d.rem = shifted;
            end
            div_d.cnt = div_q.cnt - 1'b1;
            if (div_q.cnt == CNT_BITS'(1)) begin
                div_d.busy = 1'b0;
                div_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign done     = div_q.done;
    assign quotient = div_q.quo;

    p_rem_below_divisor_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (div_q.busy && div_q.dsr != '0) |-> (div_q.rem < {1'b0, div_q.dsr}));

    p_done_closes_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        div_q.done |-> ($past(div_q.busy) && !div_q.busy));

endmodule

// File: rtl/freq_duty_meter.sv
module freq_duty_meter
    import freqm_pkg::*;
#(
    parameter int unsigned CLK_HZ        = 50_000_000,
    parameter int unsigned GATE_TICKS    = CLK_HZ / 10,
    parameter int unsigned TIMEOUT_TICKS = CLK_HZ / 5,
    parameter int unsigned CNT_W         = 32,
    parameter int unsigned DIV_W         = 48,
    parameter int unsigned FREQ_W        = 32,
    parameter int unsigned SYNC_STAGES   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sig_in,
    input  logic              btn_toggle,
    output logic              mode_recip,
    output logic [FREQ_W-1:0] freq_hz,
    output logic [6:0]        duty_pct,
    output logic              result_valid
);
    localparam int unsigned TMO_W = $clog2(TIMEOUT_TICKS + 1);
    localparam logic [DIV_W-1:0] CLK_W = DIV_W'(CLK_HZ);

    typedef struct packed {
        logic              mode;
        conv_e             conv;
        logic [TMO_W-1:0]  tmo;
        logic [CNT_W:0]    hsum;
        logic [CNT_W-1:0]  hi;
        logic [FREQ_W-1:0] f_tmp;
        logic [FREQ_W-1:0] freq;
        logic [6:0]        duty;
        logic              valid;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             rise, fall, edge_any;
    logic             tmo_fire, clr_any;
    logic             per_done, rec_done, div_done;
    logic [CNT_W-1:0] per_hi, per_lo, rec_nx, rec_ns;
    logic             div_start;
    logic [DIV_W-1:0] div_num, div_den, div_quo;
    logic [FREQ_W-1:0] freq_sat;
    logic [6:0]       duty_sat;

    freqm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(sig_in), .rise(rise), .fall(fall)
    );

    freqm_period #(.CNT_W(CNT_W)) u_period (
        .clk(clk), .rst_n(rst_n), .clr(clr_any | ctl_q.mode),
        .rise(rise), .fall(fall),
        .done(per_done), .hi_cnt(per_hi), .lo_cnt(per_lo)
    );

    freqm_recip #(.CNT_W(CNT_W), .GATE_TICKS(GATE_TICKS)) u_recip (
        .clk(clk), .rst_n(rst_n), .clr(clr_any | ~ctl_q.mode), .rise(rise),
        .done(rec_done), .nx(rec_nx), .ns(rec_ns)
    );

    freqm_divider #(.W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .clr(clr_any), .start(div_start),
        .dividend(div_num), .divisor(div_den),
        .done(div_done), .quotient(div_quo)
    );

    assign edge_any = rise | fall;
    assign tmo_fire = (ctl_q.tmo == TMO_W'(TIMEOUT_TICKS - 1)) && !edge_any && !btn_toggle;
    assign clr_any  = btn_toggle | tmo_fire;

    // saturate quotients into the output fields
    assign freq_sat = (|div_quo[DIV_W-1:FREQ_W]) ? '1 : div_quo[FREQ_W-1:0];
    assign duty_sat = (div_quo > DIV_W'(DUTY_FULL)) ? 7'(DUTY_FULL) : div_quo[6:0];

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.valid = 1'b0;
        div_start   = 1'b0;
        div_num     = '0;
        div_den     = '0;

        if (clr_any || edge_any) ctl_d.tmo = '0;
        else                     ctl_d.tmo = ctl_q.tmo + 1'b1;

        if (btn_toggle) begin
            ctl_d.mode = ~ctl_q.mode;
            ctl_d.conv = CV_IDLE;
        end else if (tmo_fire) begin
            ctl_d.conv  = CV_IDLE;
            ctl_d.freq  = '0;
            ctl_d.duty  = '0;
            ctl_d.valid = 1'b1;
        end else begin
            unique case (ctl_q.conv)
                CV_IDLE: begin
                    // measurements finishing during a conversion are dropped
                    if (!ctl_q.mode && per_done) begin
                        ctl_d.hi   = per_hi;
                        ctl_d.hsum = {1'b0, per_hi} + {1'b0, per_lo};
                        div_start  = 1'b1;
                        div_num    = CLK_W;
                        div_den    = DIV_W'({1'b0, per_hi} + {1'b0, per_lo});
                        ctl_d.conv = CV_FREQ;
                    end else if (ctl_q.mode && rec_done) begin
                        div_start  = 1'b1;
                        div_num    = CLK_W * DIV_W'(rec_nx);
                        div_den    = DIV_W'(rec_ns);
                        ctl_d.conv = CV_FREQ;
                    end
                end
                CV_FREQ: begin
                    if (div_done) begin
                        if (ctl_q.mode) begin
                            ctl_d.freq  = freq_sat;
                            ctl_d.duty  = '0;
                            ctl_d.valid = 1'b1;
                            ctl_d.conv  = CV_IDLE;
                        end else begin
                            ctl_d.f_tmp = freq_sat;
                            div_start   = 1'b1;
                            div_num     = DIV_W'(DUTY_FULL) * DIV_W'(ctl_q.hi);
                            div_den     = DIV_W'(ctl_q.hsum);
                            ctl_d.conv  = CV_DUTY;
                        end
                    end
                end
                CV_DUTY: begin
                    if (div_done) begin
                        ctl_d.freq  = ctl_q.f_tmp;
                        ctl_d.duty  = duty_sat;
                        ctl_d.valid = 1'b1;
                        ctl_d.conv  = CV_IDLE;
                    end
                end
                default: ctl_d.conv = CV_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign mode_recip   = ctl_q.mode;
    assign freq_hz      = ctl_q.freq;
    assign duty_pct     = ctl_q.duty;
    assign result_valid = ctl_q.valid;

    p_toggle_flips_r2: assert property (@(posedge clk) disable iff (!rst_n)
        btn_toggle |=> (mode_recip != $past(mode_recip)));

    p_abort_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        btn_toggle |=> !result_valid);

    p_duty_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> (duty_pct <= 7'(DUTY_FULL)));

    p_timeout_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_fire |=> (result_valid && freq_hz == '0 && duty_pct == '0));

    p_recip_duty_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid && mode_recip) |-> (duty_pct == '0));

endmodule

// File: tb/freq_duty_meter_bench.sv
module freq_duty_meter_bench;
    localparam int    GATE   = 400;
    localparam int    TMO    = 1000;
    localparam longint CLK_HZ = 50_000_000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sig_in = 1'b0;
    logic        btn = 1'b0;
    logic        mode_recip;
    logic [31:0] freq_hz;
    logic [6:0]  duty_pct;
    logic        result_valid;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;
    int hi_c = 3;
    int lo_c = 3;
    bit gen_on = 1'b0;

    always #10 clk = ~clk;

    freq_duty_meter #(
        .CLK_HZ(50_000_000), .GATE_TICKS(GATE), .TIMEOUT_TICKS(TMO)
    ) u_freq_duty_meter (
        .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .btn_toggle(btn),
        .mode_recip(mode_recip), .freq_hz(freq_hz), .duty_pct(duty_pct),
        .result_valid(result_valid)
    );

    // waveform source, phase lengths read at the start of each phase
    initial begin
        forever begin
            if (gen_on) begin
                sig_in = 1'b1;
                repeat (hi_c) @(negedge clk);
                sig_in = 1'b0;
                repeat (lo_c) @(negedge clk);
            end else begin
                sig_in = 1'b0;
                @(negedge clk);
            end
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic press();
        @(negedge clk) btn = 1'b1;
        @(negedge clk) btn = 1'b0;
    endtask

    task automatic restart();
        logic m;
        m = mode_recip;
        press();
        press();
        check(mode_recip == m, "R2 double toggle keeps mode", longint'(mode_recip), longint'(m));
    endtask

    task automatic wait_valid(output int cyc, output longint f, output longint d);
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!result_valid && cyc < 5000);
        check(result_valid == 1'b1, "R7 result strobe arrives", longint'(result_valid), 1);
        f = longint'(freq_hz);
        d = longint'(duty_pct);
        @(negedge clk);
        check(result_valid == 1'b0, "R7 strobe lasts one cycle", longint'(result_valid), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int     c;
        longint f;
        longint d;
        int     hs [6] = '{1, 2, 3, 5, 8, 13};
        int     ls [5] = '{1, 2, 4, 7, 20};
        int     ps [8] = '{2, 3, 4, 5, 7, 10, 16, 25};

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(freq_hz == 0, "R1 reset freq", longint'(freq_hz), 0);
        check(duty_pct == 0, "R1 reset duty", longint'(duty_pct), 0);
        check(result_valid == 0, "R1 reset valid", longint'(result_valid), 0);
        check(mode_recip == 0, "R1 reset mode", longint'(mode_recip), 0);

        // period method sweep (R3, R4)
        gen_on = 1'b1;
        for (int i = 0; i < 6; i++) begin
            for (int j = 0; j < 5; j++) begin
                hi_c = hs[i];
                lo_c = ls[j];
                repeat (80) @(negedge clk);
                restart();
                wait_valid(c, f, d);
                check(f == CLK_HZ / (hs[i] + ls[j]), "R3 period freq", f, CLK_HZ / (hs[i] + ls[j]));
                check(d == (100 * hs[i]) / (hs[i] + ls[j]), "R4 period duty", d, (100 * hs[i]) / (hs[i] + ls[j]));
            end
        end

        // abort during a running measurement (R9, R2)
        hi_c = 10;
        lo_c = 20;
        repeat (80) @(negedge clk);
        restart();
        wait_valid(c, f, d);
        check(d == 33, "R4 duty before abort", d, 33);
        repeat (30) @(negedge clk);
        press();
        check(mode_recip == 1'b1, "R2 toggle to reciprocal", longint'(mode_recip), 1);
        check(result_valid == 1'b0, "R9 no strobe after toggle", longint'(result_valid), 0);
        wait_valid(c, f, d);
        check(d == 0, "R9 next result from new mode", d, 0);
        check(f == CLK_HZ / 30, "R9 new mode freq", f, CLK_HZ / 30);
        check(c >= GATE, "R9 result waits a full window", c, GATE);

        // reciprocal method sweep (R5, R6)
        for (int k = 0; k < 8; k++) begin
            hi_c = (ps[k] / 2 > 0) ? ps[k] / 2 : 1;
            lo_c = ps[k] - hi_c;
            repeat (80) @(negedge clk);
            restart();
            wait_valid(c, f, d);
            check(f == CLK_HZ / ps[k], "R5 reciprocal freq", f, CLK_HZ / ps[k]);
            check(d == 0, "R5 reciprocal duty", d, 0);
            check(c >= GATE && c <= GATE + 2 * ps[k] + 80, "R6 window length", c, GATE);
        end

        // silent input (R8)
        gen_on = 1'b0;
        repeat (40) @(negedge clk);
        restart();
        wait_valid(c, f, d);
        check(f == 0, "R8 timeout freq", f, 0);
        check(d == 0, "R8 timeout duty", d, 0);
        check(c >= TMO - 5 && c <= TMO + 5, "R8 first timeout delay", c, TMO);
        wait_valid(c, f, d);
        check(c + 1 == TMO, "R8 timeout repeat interval", c + 1, TMO);
        check(f == 0, "R8 repeated timeout freq", f, 0);

        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule